// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block divides a fast internal clock down to an output clock and hands that output clock to a group of gated outputs and to one free-running output. The gated outputs can be halted by an active-low stop request that may change at any time. The request first passes through a flip-flop synchronizer in the internal clock domain. The enable state is then updated only on the internal edge that drives the divided clock low. As a result, a gated output always parks in the low state and always restarts with a high phase of full width.

Once the gated group is enabled, it stays enabled for a parameterized minimum number of output cycles. A stop request seen inside that window is remembered and carried out as soon as the window ends. Two settings cover the usual cases: a short minimum and a short synchronizer suit a slow bus clock group, and a longer minimum suits a fast processor clock group. The free-running output ignores the request completely.

Top module: `clkstop_gate`

## Requirements
- R1: `free_clk_o` stays high and low for exactly HALF internal cycles each, whatever `stop_n` does.
- R2: A low `stop_n` acts only after SYNC_STAGES synchronizer flops, and only on the internal edge where the divided clock falls. With HALF=2 and two stages, a request that drops just after a rising edge of `free_clk_o` lets exactly one more gated high pulse through.
- R3: While stopped, every gated output is held at 0. A gated output falls only on an edge where `free_clk_o` falls.
- R4: Every gated high pulse lasts exactly HALF internal cycles. A gated output rises only on an edge where `free_clk_o` rises.
- R5: With HALF=2 and two stages, releasing `stop_n` just after a rising edge of `free_clk_o` produces no gated pulse on the next rise of `free_clk_o`. The first gated rise comes on the second rise.
- R6: After the gated group is enabled, it gives at least MIN_ON high pulses before it can stop. A request held low during the whole window yields exactly MIN_ON pulses.
- R7: A stop request that comes and goes inside the minimum-enable window is kept pending. When the window expires, it removes exactly one output cycle.
- R8: All NUM_GATED gated outputs carry the same value in every cycle.
- R9: During reset (`rst`=1, synchronous), all outputs are 0. After reset the group is enabled, the synchronizer reads "run", and the minimum-enable count starts from zero.
- R10: The enable state changes only on edges after which the divided clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_n | input | 1 | Asynchronous active-low stop request for the gated group |
| gclk_o | output | NUM_GATED | Gated divided clocks |
| free_clk_o | output | 1 | Free-running divided clock, never gated |

## Verification
The hardest state to reach is a short stop pulse that arrives and leaves entirely inside the minimum-enable window. The pending logic is the only thing that remembers it. To get there, the bench releases the group with timing aligned to a rising edge of the free output. It then waits for the first gated pulse and drops `stop_n` for four internal cycles, so the request is synchronized and gone well before the window closes. The bench then counts the gated rises in a window of free-running rises, expecting exactly one to be missing. The same alignment technique drives the exact off-latency, on-latency and MIN_ON-count cases, and a reset with `stop_n` held low checks that the window restarts.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  // Phase strobes of the divided clock, valid for the coming internal edge.
  typedef struct packed {
    logic rise;  // divided clock goes high on this edge
    logic fall;  // divided clock goes low on this edge
  } phase_evt_t;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b1;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_div.sv
module clkstop_div
  import clkstop_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  output logic       div_q,
  output logic       div_d,
  output phase_evt_t evt
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap     = (cnt_q == LAST);
  assign div_d    = wrap ? ~div_q : div_q;
  assign evt.rise = wrap & ~div_q;
  assign evt.fall = wrap & div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int MIN_ON = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_req,
  input  logic       div_lvl,
  input  phase_evt_t evt,
  output logic       en_q,
  output logic       en_d
);
  localparam int CW = $clog2(MIN_ON + 2);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_ON);

  logic [CW-1:0] on_cnt_q, on_cnt_d;
  logic          pend_q, pend_d;
  logic          min_done;

  assign min_done = (on_cnt_q == LIMIT);

  always_comb begin
    en_d = en_q;
    if (evt.fall) begin
      if (en_q && min_done && (stop_req || pend_q)) en_d = 1'b0;
      else if (!en_q && !stop_req)                  en_d = 1'b1;
    end
  end

  always_comb begin
    on_cnt_d = on_cnt_q;
    if (!en_q && en_d)                           on_cnt_d = '0;
    else if (en_q && evt.rise && !min_done)      on_cnt_d = on_cnt_q + 1'b1;
  end

  always_comb begin
    pend_d = pend_q;
    if (!en_d)                 pend_d = 1'b0;
    else if (en_q && stop_req) pend_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b1;
      on_cnt_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      en_q     <= en_d;
      on_cnt_q <= on_cnt_d;
      pend_q   <= pend_d;
    end
  end

  // R10: enable moves only into a low phase of the divided clock
  p_en_low_phase_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(en_q) |-> !div_lvl);
  // R6: the group never stops before the minimum window has elapsed
  p_min_on_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(en_q) |-> $past(min_done));
  // R2: a stop only ever follows a live or remembered request
  p_stop_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(en_q) |-> $past(stop_req || pend_q));
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter int HALF        = 2,
  parameter int MIN_ON      = 10,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_GATED   = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stop_n,
  output logic [NUM_GATED-1:0] gclk_o,
  output logic                 free_clk_o
);
  logic       run_sync;
  logic       div_q, div_d;
  logic       en_q, en_d;
  phase_evt_t evt;

  clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(stop_n), .sync_out(run_sync)
  );

  clkstop_div #(.HALF(HALF)) u_div (
    .clk(clk), .rst(rst), .div_q(div_q), .div_d(div_d), .evt(evt)
  );

  clkstop_ctrl #(.MIN_ON(MIN_ON)) u_ctrl (
    .clk(clk), .rst(rst), .stop_req(~run_sync), .div_lvl(div_q),
    .evt(evt), .en_q(en_q), .en_d(en_d)
  );

  assign free_clk_o = div_q;

  generate
    for (genvar i = 0; i < NUM_GATED; i++) begin : g_out
      always_ff @(posedge clk) begin
        if (rst) gclk_o[i] <= 1'b0;
        else     gclk_o[i] <= div_d & en_d;
      end
    end
  endgenerate

  // R4: a gated rise is always a rise of the free clock
  p_rise_align_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(gclk_o[0]) |-> $rose(free_clk_o));
  // R3: a gated fall is always a fall of the free clock
  p_fall_align_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(gclk_o[0]) |-> $fell(free_clk_o));
  // R8: every gated output agrees with the first one
  p_same_r8: assert property (@(posedge clk) disable iff (rst)
    gclk_o == {NUM_GATED{gclk_o[0]}});
endmodule

// File: tb/clkstop_gate_test.sv
module clkstop_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int MIN_ON = 4;
  localparam int NG = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_n = 1'b1;
  logic [NG-1:0] gclk_o;
  logic free_clk_o;

  int n_checks = 0;
  int n_fail = 0;

  typedef struct {
    string tag;
    int    len;
    int    exp;
  } win_t;

  win_t exp_q[$];
  int   win_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkstop_gate #(.HALF(HALF), .MIN_ON(MIN_ON), .SYNC_STAGES(2), .NUM_GATED(NG)) uut (
    .clk(clk), .rst(rst), .stop_n(stop_n), .gclk_o(gclk_o), .free_clk_o(free_clk_o)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver side: queue an expected gated-rise count for a window of free rises.
  task automatic run_window(string tag, int len, int exp);
    int pre;
    pre = win_done;
    exp_q.push_back('{tag, len, exp});
    wait (win_done == pre + 1);
    @(negedge clk);
  endtask

  task automatic after_free_rise();
    @(posedge free_clk_o);
    @(negedge clk);
  endtask

  // Monitor: widths, agreement between outputs, and windowed scoreboard.
  initial begin
    logic prev_free, prev_g, seen;
    int frun, grun, left, cnt;
    bit busy;
    win_t cur;
    prev_free = 0; prev_g = 0; seen = 0; frun = 0; grun = 0;
    busy = 0; left = 0; cnt = 0;
    forever begin
      @(posedge clk);
      #1;
      if (rst) begin
        seen = 0; frun = 0; grun = 0;
        prev_free = free_clk_o; prev_g = gclk_o[0];
      end else begin
        check("R8 outputs agree", int'(gclk_o == {NG{gclk_o[0]}}), 1);
        if (free_clk_o != prev_free) begin
          if (seen) check("R1 free run length", frun, HALF);
          seen = 1; frun = 1;
        end else frun++;
        if (gclk_o[0] && !prev_g) grun = 1;
        else if (gclk_o[0]) grun++;
        else if (prev_g && grun > 0) check("R4 gated high width", grun, HALF);
        if (!busy && exp_q.size() > 0) begin
          cur = exp_q.pop_front(); busy = 1; left = cur.len; cnt = 0;
        end
        if (busy) begin
          if (gclk_o[0] && !prev_g) cnt++;
          if (free_clk_o && !prev_free) left--;
          if (left == 0) begin
            check(cur.tag, cnt, cur.exp);
            busy = 0; win_done++;
          end
        end
        prev_free = free_clk_o; prev_g = gclk_o[0];
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 gated low in reset", int'(gclk_o), 0);
    check("R9 free low in reset", int'(free_clk_o), 0);
    rst = 1'b0;
    run_window("R9 R4 normal run after reset", 8, 8);

    // R2: off latency, exactly one more pulse
    after_free_rise();
    stop_n = 1'b0;
    run_window("R2 one pulse after stop", 6, 1);
    // R3: parked low while stopped, R1 free keeps running
    run_window("R3 no pulse while stopped", 10, 0);
    check("R3 parked low", int'(gclk_o), 0);

    // R5: on latency
    after_free_rise();
    stop_n = 1'b1;
    run_window("R5 no pulse on first rise", 1, 0);
    run_window("R5 pulse on second rise", 1, 1);
    run_window("R5 running after release", 3, 3);

    // stop again to prepare the minimum-enable case
    after_free_rise();
    stop_n = 1'b0;
    run_window("R2 one pulse after stop", 6, 1);

    // R6: release, then request again at once: exactly MIN_ON pulses
    after_free_rise();
    stop_n = 1'b1;
    after_free_rise();
    stop_n = 1'b0;
    run_window("R6 exactly MIN_ON pulses", 10, MIN_ON);
    check("R3 parked low after window", int'(gclk_o), 0);

    // R7: short request inside the window is held pending
    after_free_rise();
    stop_n = 1'b1;
    @(posedge free_clk_o);
    after_free_rise();
    fork
      run_window("R7 pending stop drops one cycle", 8, 7);
      begin
        stop_n = 1'b0;
        repeat (4) @(negedge clk);
        stop_n = 1'b1;
      end
    join

    // R9: reset clears the window while a request is held
    stop_n = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 gated low in second reset", int'(gclk_o), 0);
    check("R9 free low in second reset", int'(free_clk_o), 0);
    rst = 1'b0;
    run_window("R9 R6 window restarts after reset", 10, MIN_ON);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule